// File: doc/BRIEF.md
# Serial Response Byte FIFO

This block collects the bytes that a half-duplex multi-lane serial flash receiver produces, one per cycle at most, and hands them to a host as 32-bit words through a register-read pop port. The host polls a status word that reports how many bytes are held, whether quarter, half or full capacity has been reached, and whether the buffer is empty. A level interrupt signals that data is waiting. A sticky error interrupt records any pop made while nothing was buffered.

Each pop returns up to four bytes, with the oldest byte in the least significant lane. When fewer than four bytes remain, the pop returns only those bytes, with the unused upper lanes forced to zero, and frees only what it returned. The read position can therefore sit at any byte offset. A flush input models a write-one-to-reset control and empties the buffer at once. The storage is four byte lanes, each `DEPTH_WORDS` entries deep, and holds 64 bytes by default.

Top module: `resp_byte_fifo`

## Requirements
- R1: After reset the count field is 0, statusWord equals 12'h800 (only the empty bit set), and irqReady and irqUnderrun are both 0.
- R2: popData presents the buffered bytes in arrival order: the oldest byte in bits 7:0, the next in 15:8, then 23:16, then 31:24.
- R3: statusWord bits 10:4 hold the number of buffered bytes. An accepted write adds 1, and a pop removes min(count, 4).
- R4: statusWord bit 0 is 1 when at least 1 byte is held. Bits 1, 2 and 3 are 1 when at least 16, 32 and 64 bytes are held.
- R5: statusWord bit 11 is 1 exactly when no byte is held.
- R6: When fewer than 4 bytes are held, popData carries them in the low lanes with the upper lanes zero. A pop frees only those bytes, and later bytes follow on directly from that byte position.
- R7: A cycle with flushReq high empties the buffer, ignores any write or pop in that cycle, and leaves no earlier byte readable afterwards.
- R8: A pop while the count is 0 sets irqUnderrun and leaves the count unchanged. irqUnderrun stays set until a cycle with underrunClr high and no new underrun.
- R9: irqReady is 1 exactly when at least one byte is buffered.
- R10: A write while 64 bytes are held is dropped, and the stored bytes are returned unchanged.
- R11: A write and a pop in the same cycle both take effect, so the count changes by +1 minus the bytes popped. Fullness for the write is judged on the count before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Receive byte strobe |
| wrByte | input | 8 | Received byte |
| popEn | input | 1 | Data register read strobe, pops one word |
| popData | output | 32 | Word returned by the current pop |
| flushReq | input | 1 | Soft reset request, empties the buffer |
| underrunClr | input | 1 | Write-one-to-clear for the underrun flag |
| statusWord | output | 12 | Ready, threshold, count and empty fields |
| irqReady | output | 1 | Data available interrupt |
| irqUnderrun | output | 1 | Sticky underrun error interrupt |

## Verification
The hardest state to reach is a read position that is not word aligned and that wraps past the top of storage. A full-word pop only ever moves it in steps of four from zero. To get there, the stimulus repeatedly writes three bytes and pops once, over more than a full trip around the buffer, and a byte queue in the bench predicts every word. A fill-level sweep from 0 to 64 bytes, each level followed by a full drain, covers every threshold and every partial tail length.

// File: rtl/resp_fifo_pkg.sv
package resp_fifo_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic             wrAccept;
    logic [LANES-1:0] laneValid;
  } fifoStrobe_t;
endpackage

// File: rtl/resp_fifo_ctrl.sv
module resp_fifo_ctrl
  import resp_fifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  localparam int CAP  = DEPTH_WORDS * LANES,
  localparam int PTRW = $clog2(CAP),
  localparam int CNTW = $clog2(CAP + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            popEn,
  input  logic            flushReq,
  input  logic            underrunClr,
  output fifoStrobe_t     strobe,
  output logic [PTRW-1:0] wrPtr,
  output logic [PTRW-1:0] rdPtr,
  output logic [CNTW-1:0] fillCount,
  output logic            underrunFlag
);
  logic            isFull;
  logic            isEmpty;
  logic [CNTW-1:0] popCount;

  assign isFull  = (fillCount == CNTW'(CAP));
  assign isEmpty = (fillCount == '0);

  always_comb begin
    strobe.wrAccept = wrEn && !isFull && !flushReq;
    popCount = '0;
    if (popEn && !flushReq)
      popCount = (fillCount >= CNTW'(LANES)) ? CNTW'(LANES) : fillCount;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_valid
    assign strobe.laneValid[i] = (fillCount > CNTW'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (flushReq) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      wrPtr     <= wrPtr + PTRW'(strobe.wrAccept);
      rdPtr     <= rdPtr + PTRW'(popCount);
      fillCount <= fillCount + CNTW'(strobe.wrAccept) - popCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 underrunFlag <= 1'b0;
    else if (popEn && isEmpty) underrunFlag <= 1'b1;
    else if (underrunClr)      underrunFlag <= 1'b0;
  end
endmodule

// File: rtl/resp_fifo_store.sv
module resp_fifo_store
  import resp_fifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  localparam int CAP   = DEPTH_WORDS * LANES,
  localparam int PTRW  = $clog2(CAP),
  localparam int LANEW = $clog2(LANES)
) (
  input  logic             clk,
  input  fifoStrobe_t      strobe,
  input  logic [PTRW-1:0]  wrPtr,
  input  logic [PTRW-1:0]  rdPtr,
  input  logic [7:0]       wrByte,
  output logic [8*LANES-1:0] headWord
);
  logic [PTRW-1:0] rdAddr   [LANES];
  logic [7:0]      laneByte [LANES][LANES];

  for (genvar p = 0; p < LANES; p++) begin : g_addr
    assign rdAddr[p] = rdPtr + PTRW'(p);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneMem [DEPTH_WORDS];

    always_ff @(posedge clk) begin
      if (strobe.wrAccept && (wrPtr[LANEW-1:0] == LANEW'(l)))
        laneMem[wrPtr[PTRW-1:LANEW]] <= wrByte;
    end

    for (genvar p = 0; p < LANES; p++) begin : g_rd
      assign laneByte[l][p] = laneMem[rdAddr[p][PTRW-1:LANEW]];
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_out
    assign headWord[8*p +: 8] = strobe.laneValid[p]
                              ? laneByte[rdAddr[p][LANEW-1:0]][p] : 8'h00;
  end
endmodule

// File: rtl/resp_byte_fifo.sv
module resp_byte_fifo
  import resp_fifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrByte,
  input  logic        popEn,
  output logic [31:0] popData,
  input  logic        flushReq,
  input  logic        underrunClr,
  output logic [11:0] statusWord,
  output logic        irqReady,
  output logic        irqUnderrun
);
  localparam int CAP  = DEPTH_WORDS * LANES;
  localparam int PTRW = $clog2(CAP);
  localparam int CNTW = $clog2(CAP + 1);

  fifoStrobe_t     strobe;
  logic [PTRW-1:0] wrPtr;
  logic [PTRW-1:0] rdPtr;
  logic [CNTW-1:0] fillCount;

  resp_fifo_ctrl #(.DEPTH_WORDS(DEPTH_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .popEn(popEn),
    .flushReq(flushReq), .underrunClr(underrunClr),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fillCount(fillCount), .underrunFlag(irqUnderrun)
  );

  resp_fifo_store #(.DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrByte(wrByte), .headWord(popData)
  );

  always_comb begin
    statusWord[0]    = (fillCount != '0);
    statusWord[1]    = (fillCount >= CNTW'(CAP / 4));
    statusWord[2]    = (fillCount >= CNTW'(CAP / 2));
    statusWord[3]    = (fillCount >= CNTW'(CAP));
    statusWord[10:4] = 7'(fillCount);
    statusWord[11]   = (fillCount == '0);
  end

  assign irqReady = (fillCount != '0);
endmodule

// File: rtl/resp_byte_fifo_chk.sv
module resp_byte_fifo_chk #(
  parameter int DEPTH_WORDS = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       popEn,
  input logic       flushReq,
  input logic       underrunClr,
  input logic [6:0] fill,
  input logic       emptyBit,
  input logic       irqReady,
  input logic       irqUnderrun
);
  localparam int CAP = DEPTH_WORDS * 4;

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= 7'(CAP));

  p_write_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !popEn && !flushReq && fill < 7'(CAP))
      |=> fill == 7'($past(fill) + 7'd1));

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !wrEn && !flushReq && fill != 7'd0)
      |=> fill == (($past(fill) >= 7'd4) ? 7'($past(fill) - 7'd4) : 7'd0));

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (fill == 7'd0) && emptyBit);

  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fill == 7'(CAP) && wrEn && !popEn && !flushReq) |=> fill == 7'(CAP));

  p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && fill == 7'd0) |=> irqUnderrun);

  p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqUnderrun && !underrunClr) |=> irqUnderrun);

  p_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqReady |-> !emptyBit);
endmodule

bind resp_byte_fifo resp_byte_fifo_chk #(.DEPTH_WORDS(DEPTH_WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .popEn(popEn),
  .flushReq(flushReq), .underrunClr(underrunClr),
  .fill(statusWord[10:4]), .emptyBit(statusWord[11]),
  .irqReady(irqReady), .irqUnderrun(irqUnderrun)
);

// File: tb/resp_byte_fifo_bench.sv
module resp_byte_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrByte = 8'h00;
  logic        popEn = 1'b0;
  logic [31:0] popData;
  logic        flushReq = 1'b0;
  logic        underrunClr = 1'b0;
  logic [11:0] statusWord;
  logic        irqReady;
  logic        irqUnderrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  resp_byte_fifo u_resp_byte_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .popEn(popEn),
    .popData(popData), .flushReq(flushReq), .underrunClr(underrunClr),
    .statusWord(statusWord), .irqReady(irqReady), .irqUnderrun(irqUnderrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    wrEn = 1'b1; wrByte = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic popWord(output logic [31:0] w);
    w = popData;
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic flushNow();
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic int fillOf();
    return int'(statusWord[10:4]);
  endfunction

  initial begin
    logic [31:0] w;
    logic [31:0] expW;
    logic [7:0]  q[$];
    int rem;
    int idx;
    int take;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(statusWord == 12'h800, "R1 status", 32'(statusWord), 32'h800);
    chk(irqReady == 1'b0, "R1 irqReady", 32'(irqReady), 0);
    chk(irqUnderrun == 1'b0, "R1 irqUnderrun", 32'(irqUnderrun), 0);

    // Fill-level sweep, R2 R3 R4 R5 R6 R9
    for (int n = 0; n <= 64; n++) begin
      flushNow();
      for (int i = 0; i < n; i++) pushByte(pat(n, i));
      chk(fillOf() == n, "R3 count after fill", 32'(fillOf()), 32'(n));
      chk(statusWord[0] == (n >= 1) && statusWord[1] == (n >= 16) &&
          statusWord[2] == (n >= 32) && statusWord[3] == (n >= 64),
          "R4 thresholds", 32'(statusWord[3:0]),
          32'({n >= 64, n >= 32, n >= 16, n >= 1}));
      chk(statusWord[11] == (n == 0), "R5 empty", 32'(statusWord[11]), 32'(n == 0));
      chk(irqReady == (n != 0), "R9 ready irq", 32'(irqReady), 32'(n != 0));
      rem = n; idx = 0;
      while (rem > 0) begin
        take = (rem >= 4) ? 4 : rem;
        expW = '0;
        for (int k = 0; k < take; k++) expW[8*k +: 8] = pat(n, idx + k);
        popWord(w);
        chk(w == expW, (take == 4) ? "R2 word order" : "R6 partial tail", w, expW);
        rem -= take; idx += take;
        chk(fillOf() == rem, "R3 count after pop", 32'(fillOf()), 32'(rem));
      end
    end

    // R8 underrun
    popWord(w);
    chk(irqUnderrun == 1'b1, "R8 underrun set", 32'(irqUnderrun), 1);
    chk(fillOf() == 0, "R8 count unchanged", 32'(fillOf()), 0);
    pushByte(8'h3C);
    chk(irqUnderrun == 1'b1, "R8 underrun sticky", 32'(irqUnderrun), 1);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;
    chk(irqUnderrun == 1'b0, "R8 underrun cleared", 32'(irqUnderrun), 0);
    chk(popData == 32'h3C, "R8 data intact", popData, 32'h3C);

    // R10 full drop
    flushNow();
    for (int i = 0; i < 64; i++) pushByte(8'(i ^ 8'h5A));
    for (int i = 0; i < 5; i++) pushByte(8'hEE);
    chk(fillOf() == 64, "R10 count at full", 32'(fillOf()), 64);
    for (int j = 0; j < 16; j++) begin
      for (int k = 0; k < 4; k++) expW[8*k +: 8] = 8'((4*j + k) ^ 8'h5A);
      popWord(w);
      chk(w == expW, "R10 data unchanged", w, expW);
    end

    // R7 flush with write in same cycle
    for (int i = 0; i < 10; i++) pushByte(8'(8'hA0 + i));
    wrEn = 1'b1; wrByte = 8'h77; flushReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; flushReq = 1'b0;
    chk(fillOf() == 0, "R7 count cleared", 32'(fillOf()), 0);
    chk(popData == 32'h0, "R7 nothing readable", popData, 0);
    pushByte(8'h11); pushByte(8'h22);
    chk(popData == 32'h2211, "R7 only new bytes", popData, 32'h2211);

    // R11 simultaneous write and pop
    flushNow();
    for (int i = 0; i < 6; i++) pushByte(8'(8'hC0 + i));
    expW = 32'hC3C2C1C0;
    w = popData;
    wrEn = 1'b1; wrByte = 8'hD9; popEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; popEn = 1'b0;
    chk(w == expW, "R11 popped word", w, expW);
    chk(fillOf() == 3, "R11 count net", 32'(fillOf()), 3);
    chk(popData == 32'h00D9C5C4, "R11 following word", popData, 32'h00D9C5C4);
    flushNow();
    for (int i = 0; i < 64; i++) pushByte(8'(i));
    wrEn = 1'b1; wrByte = 8'hFF; popEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; popEn = 1'b0;
    chk(fillOf() == 60, "R11 full write dropped", 32'(fillOf()), 60);

    // R6 R2 stream with unaligned, wrapping read position
    flushNow();
    q.delete();
    idx = 0;
    for (int it = 0; it < 40; it++) begin
      for (int b = 0; b < 3; b++) begin
        pushByte(8'(idx));
        q.push_back(8'(idx));
        idx++;
      end
      take = (q.size() >= 4) ? 4 : q.size();
      expW = '0;
      for (int k = 0; k < take; k++) expW[8*k +: 8] = q[k];
      popWord(w);
      for (int k = 0; k < take; k++) void'(q.pop_front());
      chk(w == expW, "R6 stream word", w, expW);
      chk(fillOf() == q.size(), "R6 stream count", 32'(fillOf()), 32'(q.size()));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule